// File: doc/BRIEF.md
# Self-Programming Command Register with Configuration Readback

This block is the command register of a small microcontroller's self-programming unit. The CPU writes a five-bit command code into it. A legal code arms a short, cycle-counted window. In that window the next program-memory store or load instruction is treated as part of the command rather than as an ordinary access. The window closes by itself when that instruction arrives or when its cycle budget runs out.

One command, the configuration read (`01001`), redirects a program-memory load. During its window, a load whose pointer is 0 to 3 returns a lock or fuse byte instead of flash data. Internally the configuration inputs are flags with 1 meaning programmed. They are inverted on the way out, so programmed bits read as 0.

While the data EEPROM is busy writing, command writes are refused and configuration reads are not redirected. The flash erase and write engine and the EEPROM itself sit outside this block.

Top module: `spm_cmd_unit`

## Requirements
- R1: A write whose low five bits are 10001, 01001, 00101, 00011 or 00001 loads those bits into `regVal[4:0]`. `regVal[7:5]` always reads 0. Bit 0 is the enable bit, and 01001 is the configuration-read command.
- R2: A write with any other low five-bit pattern leaves `regVal` unchanged.
- R3: While `eeBusy` is high, a register write has no effect.
- R4: While `eeBusy` is high, a load in an open configuration-read window is not redirected (`rdValid` stays 0) and the window stays open.
- R5: After a configuration-read command is written, a load in any of the next three cycles with pointer 0 to 3 gives `rdValid`=1 and the byte on `rdData` one cycle later. The register then clears to 0.
- R6: A configuration-read window clears after three cycles without a load. Any other armed command clears after four cycles without a store. A store inside any armed window clears the register.
- R7: Pointer 0 returns the fuse low byte, 1 the lock byte, 2 the extended fuse byte and 3 the fuse high byte. A pointer of 4 or more returns nothing (`rdValid`=0) but still closes the window.
- R8: Returned bits are the inversion of the programmed flags: a programmed bit reads 0 and an unprogrammed bit reads 1.
- R9: Only bits 1:0 of the lock byte carry lock flags. Bits 7:2 always read 1.
- R10: A load that lands on the last cycle of the window, the cycle in which it would expire, is still redirected.
- R11: With no window open, a load is not redirected: `rdValid` is 0 and `rdData` is 0.
- R12: After reset, `regVal` is 0 and `rdValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | CPU write strobe for the command register |
| regWrData | input | 8 | CPU write data |
| lpmPulse | input | 1 | One-cycle pulse per program-memory load |
| spmPulse | input | 1 | One-cycle pulse per program-memory store |
| ptrAddr | input | 16 | Pointer address of the load |
| cfgLockProg | input | 8 | Lock flags, 1 = programmed (bits 1:0 used) |
| cfgFuseLowProg | input | 8 | Fuse low flags, 1 = programmed |
| cfgFuseHighProg | input | 8 | Fuse high flags, 1 = programmed |
| cfgFuseExtProg | input | 8 | Extended fuse flags, 1 = programmed |
| eeBusy | input | 1 | Data EEPROM write in progress |
| rdData | output | 8 | Redirected read byte |
| rdValid | output | 1 | Redirect valid, one cycle after the load |
| regVal | output | 8 | Current register value |

## Verification
Two events can fall on the same clock edge: the expiry of the configuration-read window and the load instruction it is waiting for. The bench writes the read command and places the load exactly three cycles later, on the edge where the counter hits its limit. It expects the configuration byte, and it expects the register to be clear afterwards. A load one cycle later must come back unredirected. A second overlap is a command write or a load while the EEPROM is busy. That is provoked by raising `eeBusy` around each and checking that the register holds its value and that no data is returned.

// File: rtl/spm_pkg.sv
package spm_pkg;

  localparam int CMD_W = 5;

  localparam logic [CMD_W-1:0] CMD_CFG_RD = 5'b01001;
  localparam logic [CMD_W-1:0] CMD_ENABLE = 5'b00001;
  localparam logic [CMD_W-1:0] CMD_ERASE  = 5'b00011;
  localparam logic [CMD_W-1:0] CMD_WRITE  = 5'b00101;
  localparam logic [CMD_W-1:0] CMD_REL    = 5'b10001;

  // strobes from control to datapath
  typedef struct packed {
    logic rbFire;   // redirected configuration read happens this cycle
    logic rbLast;   // it happens on the final window cycle
  } spmStrobe_t;

  function automatic logic cmdLegal(input logic [CMD_W-1:0] c);
    return (c == CMD_CFG_RD) || (c == CMD_ENABLE) || (c == CMD_ERASE) ||
           (c == CMD_WRITE)  || (c == CMD_REL);
  endfunction

endpackage

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RD_WIN = 3,
  parameter int WR_WIN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              lpmPulse,
  input  logic              spmPulse,
  input  logic              eeBusy,
  output logic [CMD_W-1:0]  cmdBits,
  output spmStrobe_t        strb
);

  localparam int MAX_WIN = (RD_WIN > WR_WIN) ? RD_WIN : WR_WIN;
  localparam int CNT_W   = $clog2(MAX_WIN + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_WIN - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_WIN - 1);

  logic [CMD_W-1:0] cmdReg;
  logic [CNT_W-1:0] winCnt;
  logic             armed;
  logic             isCfgRd;
  logic             wrAccept;
  logic             rbFire;
  logic             spmHit;
  logic             lastCyc;

  always_comb begin
    armed    = cmdReg[0];
    isCfgRd  = (cmdReg == CMD_CFG_RD);
    wrAccept = regWrEn && !eeBusy && cmdLegal(regWrData[CMD_W-1:0]);
    rbFire   = armed && isCfgRd && lpmPulse && !eeBusy;
    spmHit   = armed && spmPulse;
    lastCyc  = armed && (winCnt == (isCfgRd ? RD_LAST : WR_LAST));
  end

  // a load on the final cycle is still served, then the window closes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
      winCnt <= '0;
    end else if (wrAccept) begin
      cmdReg <= regWrData[CMD_W-1:0];
      winCnt <= '0;
    end else if (rbFire || spmHit || lastCyc) begin
      cmdReg <= '0;
      winCnt <= '0;
    end else if (armed) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  assign cmdBits     = cmdReg;
  assign strb.rbFire = rbFire;
  assign strb.rbLast = rbFire && lastCyc;

endmodule

// File: rtl/spm_cfg_dp.sv
module spm_cfg_dp
  import spm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 16,
  parameter int LOCK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  spmStrobe_t        strb,
  input  logic [PTR_W-1:0]  ptrAddr,
  input  logic [DATA_W-1:0] cfgLockProg,
  input  logic [DATA_W-1:0] cfgFuseLowProg,
  input  logic [DATA_W-1:0] cfgFuseHighProg,
  input  logic [DATA_W-1:0] cfgFuseExtProg,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int NUM_SRC = 4;
  localparam int SEL_W   = $clog2(NUM_SRC);

  logic [DATA_W-1:0] srcByte [NUM_SRC];
  logic [DATA_W-1:0] lockView;
  logic              inRange;
  logic [SEL_W-1:0]  sel;

  // lock byte: unused positions read as unprogrammed
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_lock
      if (gi < LOCK_W) begin : g_used
        assign lockView[gi] = ~cfgLockProg[gi];
      end else begin : g_pad
        assign lockView[gi] = 1'b1;
      end
    end
  endgenerate

  // pointer order: 0 fuse low, 1 lock, 2 extended fuse, 3 fuse high
  assign srcByte[0] = ~cfgFuseLowProg;
  assign srcByte[1] = lockView;
  assign srcByte[2] = ~cfgFuseExtProg;
  assign srcByte[3] = ~cfgFuseHighProg;

  assign inRange = (ptrAddr < PTR_W'(NUM_SRC));
  assign sel     = ptrAddr[SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else if (strb.rbFire && inRange) begin
      rdData  <= srcByte[sel];
      rdValid <= 1'b1;
    end else begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end
  end

endmodule

// File: rtl/spm_cmd_unit.sv
module spm_cmd_unit
  import spm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 16,
  parameter int LOCK_W = 2,
  parameter int RD_WIN = 3,
  parameter int WR_WIN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              lpmPulse,
  input  logic              spmPulse,
  input  logic [PTR_W-1:0]  ptrAddr,
  input  logic [DATA_W-1:0] cfgLockProg,
  input  logic [DATA_W-1:0] cfgFuseLowProg,
  input  logic [DATA_W-1:0] cfgFuseHighProg,
  input  logic [DATA_W-1:0] cfgFuseExtProg,
  input  logic              eeBusy,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [DATA_W-1:0] regVal
);

  spmStrobe_t       strb;
  logic [CMD_W-1:0] cmdBits;

  spm_ctrl #(.DATA_W(DATA_W), .RD_WIN(RD_WIN), .WR_WIN(WR_WIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .lpmPulse(lpmPulse), .spmPulse(spmPulse), .eeBusy(eeBusy),
    .cmdBits(cmdBits), .strb(strb)
  );

  spm_cfg_dp #(.DATA_W(DATA_W), .PTR_W(PTR_W), .LOCK_W(LOCK_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ptrAddr(ptrAddr),
    .cfgLockProg(cfgLockProg), .cfgFuseLowProg(cfgFuseLowProg),
    .cfgFuseHighProg(cfgFuseHighProg), .cfgFuseExtProg(cfgFuseExtProg),
    .rdData(rdData), .rdValid(rdValid)
  );

  assign regVal = {{(DATA_W-CMD_W){1'b0}}, cmdBits};

endmodule

// File: rtl/spm_cmd_chk.sv
module spm_cmd_chk #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 16,
  parameter int WR_WIN = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              lpmPulse,
  input logic [PTR_W-1:0]  ptrAddr,
  input logic              eeBusy,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic [DATA_W-1:0] regVal
);

  logic [7:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN)          runLen <= '0;
    else if (regWrEn)   runLen <= '0;
    else if (regVal[0]) runLen <= runLen + 1'b1;
    else                runLen <= '0;
  end

  AST_REG_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    regVal[4:0] inside {5'b00000, 5'b10001, 5'b01001, 5'b00101, 5'b00011, 5'b00001}
    && regVal[DATA_W-1:5] == '0); // R1

  AST_EE_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    eeBusy && regWrEn && regVal == '0 |=> regVal == '0); // R3

  AST_VALID_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(regVal[4:0] == 5'b01001 && lpmPulse && !eeBusy &&
                      ptrAddr < PTR_W'(4))); // R5

  AST_CLEAR_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !$past(regWrEn) |-> regVal == '0); // R5

  AST_LOCK_PAD_ONES: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && $past(ptrAddr) == PTR_W'(1) |-> rdData[DATA_W-1:2] == '1); // R9

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    regVal[0] |-> runLen < 8'(WR_WIN)); // R6

  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> rdData == '0); // R11

endmodule

bind spm_cmd_unit spm_cmd_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W), .WR_WIN(WR_WIN)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .lpmPulse(lpmPulse),
  .ptrAddr(ptrAddr), .eeBusy(eeBusy), .rdData(rdData), .rdValid(rdValid),
  .regVal(regVal)
);

// File: tb/sim_spm_cmd_unit.sv
`timescale 1ns/1ps
module sim_spm_cmd_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic        lpmPulse = 1'b0;
  logic        spmPulse = 1'b0;
  logic [15:0] ptrAddr = '0;
  logic [7:0]  cfgLockProg = 8'hF1;
  logic [7:0]  cfgFuseLowProg = 8'h62;
  logic [7:0]  cfgFuseHighProg = 8'hD9;
  logic [7:0]  cfgFuseExtProg = 8'h07;
  logic        eeBusy = 1'b0;
  logic [7:0]  rdData;
  logic        rdValid;
  logic [7:0]  regVal;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] expQ [$];

  always #2 clk = ~clk;

  spm_cmd_unit u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .lpmPulse(lpmPulse), .spmPulse(spmPulse), .ptrAddr(ptrAddr),
    .cfgLockProg(cfgLockProg), .cfgFuseLowProg(cfgFuseLowProg),
    .cfgFuseHighProg(cfgFuseHighProg), .cfgFuseExtProg(cfgFuseExtProg),
    .eeBusy(eeBusy), .rdData(rdData), .rdValid(rdValid), .regVal(regVal)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every redirected byte must match the head of the scoreboard
  always @(negedge clk) begin
    if (rstN && !done && rdValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5: actual=%h expected=no redirect", rdData);
      end else begin
        check("R5/R7 scoreboard", rdData, expQ.pop_front());
      end
    end
  end

  // returns at the negedge after the write edge
  task automatic cpuWrite(input logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  // load sampled on the k-th edge after the write; returns after it
  task automatic loadAt(input int k, input logic [15:0] a, input bit expect_hit,
                        input logic [7:0] expByte);
    repeat (k-1) @(negedge clk);
    ptrAddr = a; lpmPulse = 1'b1;
    if (expect_hit) expQ.push_back(expByte);
    @(negedge clk); lpmPulse = 1'b0;
  endtask

  task automatic storeAt(input int k);
    repeat (k-1) @(negedge clk);
    spmPulse = 1'b1;
    @(negedge clk); spmPulse = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R12 reg", regVal, 8'h00);
    check("R12 valid", {7'b0, rdValid}, 8'h00);

    // R11: load with nothing armed
    loadAt(1, 16'h0000, 1'b0, 8'h00);
    check("R11 valid", {7'b0, rdValid}, 8'h00);
    check("R11 data", rdData, 8'h00);

    // R1: legal command loads, upper bits read zero
    cpuWrite(8'hE3);
    check("R1 load", regVal, 8'h03);
    // R2: illegal pattern keeps old value
    cpuWrite(8'h06);
    check("R2 ignore", regVal, 8'h03);
    // R6: store command expires after four cycles (window restarted by nothing)
    repeat (4) @(negedge clk);
    check("R6 store expiry", regVal, 8'h00);

    cpuWrite(8'h01);
    repeat (3) @(negedge clk);
    check("R6 still armed at 3", regVal, 8'h01);
    @(negedge clk);
    check("R6 cleared at 4", regVal, 8'h00);

    cpuWrite(8'h07);
    check("R2 illegal from idle", regVal, 8'h00);

    // R6: store inside window clears
    cpuWrite(8'h05);
    storeAt(2);
    check("R6 store consumes", regVal, 8'h00);

    // R5/R8: fuse low, first cycle
    cpuWrite(8'h09);
    check("R1 read cmd", regVal, 8'h09);
    loadAt(1, 16'h0000, 1'b1, 8'h9D);
    check("R5 cleared after read", regVal, 8'h00);

    // R9: lock byte, upper flags ignored and padded with ones
    cpuWrite(8'h09);
    loadAt(2, 16'h0001, 1'b1, 8'hFE);
    // R10: extended fuse on the final window cycle
    cpuWrite(8'h09);
    loadAt(3, 16'h0002, 1'b1, 8'hF8);
    check("R10 cleared", regVal, 8'h00);
    // R8: fuse high
    cpuWrite(8'h09);
    loadAt(1, 16'h0003, 1'b1, 8'h26);

    // R6: read window expires after three cycles; later load is normal (R11)
    cpuWrite(8'h09);
    repeat (3) @(negedge clk);
    check("R6 read expiry", regVal, 8'h00);
    loadAt(1, 16'h0000, 1'b0, 8'h00);
    check("R11 after expiry", {7'b0, rdValid}, 8'h00);

    // R7: pointer out of range closes window without data
    cpuWrite(8'h09);
    loadAt(1, 16'h0004, 1'b0, 8'h00);
    check("R7 out of range valid", {7'b0, rdValid}, 8'h00);
    check("R7 out of range clears", regVal, 8'h00);

    // R3: write blocked while busy
    eeBusy = 1'b1;
    cpuWrite(8'h09);
    check("R3 blocked write", regVal, 8'h00);
    eeBusy = 1'b0;

    // R4: busy load not redirected, window stays open
    cpuWrite(8'h09);
    eeBusy = 1'b1;
    loadAt(1, 16'h0000, 1'b0, 8'h00);
    check("R4 no redirect", {7'b0, rdValid}, 8'h00);
    check("R4 window open", regVal, 8'h09);
    eeBusy = 1'b0;
    loadAt(1, 16'h0003, 1'b1, 8'h26);

    repeat (2) @(negedge clk);
    check("R5 scoreboard drained", 8'(expQ.size()), 8'h00);
    finishRun();
  end

endmodule